// File: doc/BRIEF.md
# Error Record Group Status Reader

This block serves a privileged system-register read that returns a 64-bit status word for one group of error records. Each bit of the word shows whether one record in the group holds an error. A request carries the access encoding, the current privilege level, the record-select value, the implemented record count and the trap-control bits of the higher privilege levels. The block registers the request. One cycle later it gives one outcome: a successful read with data, an undefined-instruction result, or a trap to level 2 or level 3 with an exception class.

A small state machine controls the response. It has two states. `ST_IDLE` means no response is pending. `ST_RESP` means a captured request is being answered in this cycle. There are two transitions. **capture** goes from either state to `ST_RESP` in any cycle where `req_i` is high, so requests may come back to back. **retire** goes from either state to `ST_IDLE` in any cycle where `req_i` is low. Reset puts the machine in `ST_IDLE`. The per-record valid and implemented flags are read live during the response cycle. All other request fields come from the captured copy.

Top module: `errgrp_status_rd`

## Requirements
- R1: One cycle after each clock edge at which `req_i` is high, `resp_valid_o` is high for exactly one cycle. When no request was taken at the previous edge, `resp_valid_o` is low.
- R2: While `resp_valid_o` is high, `resp_kind_o` has exactly one bit set. The bits mean: bit0 = read done, bit1 = undefined, bit2 = trap to level 2, bit3 = trap to level 3. While `resp_valid_o` is low, `resp_kind_o` is zero.
- R3: The access is recognised only when op0=2'b11, op1=3'b000, CRn=4'b0101, CRm=4'b0011 and op2=3'b010, and `feat_en_i` is high. Any other encoding, or the feature being absent, gives undefined.
- R4: A recognised access at level 0 (`cur_el_i`=0) is always undefined.
- R5: At level 1 the checks apply in this order, and the first that holds decides the outcome:
  - level 3 present, level-3 error trap set and undefined-priority set gives undefined;
  - level 2 active with its error trap set gives a trap to level 2;
  - level 2 active, fine-grained trap set present, and either (level 3 present and its fine-grained enable clear) or the per-register read enable clear gives a trap to level 2;
  - level 3 present with its error trap set gives undefined if the debug-undefined condition holds, and otherwise a trap to level 3;
  - if none of these holds, the read is done.
- R6: At level 2 only the two level-3 checks of R5 apply, in the same order. The level-2 controls have no effect.
- R7: A recognised access at level 3 always completes as a read.
- R8: `trap_ec_o` is 6'h18 for either trap outcome and zero otherwise.
- R9: On a read, bit q of `rdata_o` is the record's valid flag AND its implemented flag, for record q + 64×`rec_sel_i[15:6]`. Records at or above NREC read 0.
- R10: When `rec_count_i` is zero, or `rec_sel_i` ≥ `rec_count_i`, a read returns all zeros. This includes the case where the select value equals the count.
- R11: `rdata_o` is zero for every outcome other than a read.
- R12: During reset and after it, before the first request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request, captured at the clock edge |
| acc_op0_i | input | 2 | Access encoding field op0 |
| acc_op1_i | input | 3 | Access encoding field op1 |
| acc_crn_i | input | 4 | Access encoding field CRn |
| acc_crm_i | input | 4 | Access encoding field CRm |
| acc_op2_i | input | 3 | Access encoding field op2 |
| feat_en_i | input | 1 | Group-status feature implemented |
| cur_el_i | input | 2 | Current privilege level 0..3 |
| rec_sel_i | input | 16 | Record-select value; bits [15:6] pick the group |
| rec_count_i | input | 16 | Number of implemented records |
| rec_valid_i | input | NREC | Per-record error-valid flag |
| rec_impl_i | input | NREC | Record implemented and supports this reporting |
| el3_impl_i | input | 1 | Level 3 present |
| el2_active_i | input | 1 | Level 2 enabled for the current context |
| l3_err_trap_i | input | 1 | Level-3 error-register trap control |
| l3_undef_prio_i | input | 1 | Undefined takes priority over traps |
| l3_dbg_undef_i | input | 1 | Debug-disable condition makes a level-3 trap undefined |
| l2_err_trap_i | input | 1 | Level-2 error-register trap control |
| fgt2_impl_i | input | 1 | Second fine-grained trap set present |
| l3_fgt2_en_i | input | 1 | Level-3 enable for the fine-grained trap set |
| l2_grp_rd_en_i | input | 1 | Per-register read enable (0 traps to level 2) |
| resp_valid_o | output | 1 | Response present this cycle |
| resp_kind_o | output | 4 | One-hot outcome |
| rdata_o | output | 64 | Group status word |
| trap_ec_o | output | 6 | Exception class for traps |

## Verification
A wrong state would show up at the ports within one cycle. A machine stuck in `ST_RESP` gives a response with no request behind it. One that fails to reach `ST_RESP` drops a response, and R1 catches both at the next sample. A wrong order in the trap checks gives the wrong one-hot outcome only for some trap-bit combinations. For that reason every privilege level is swept against every combination of the nine control bits. A wrong group mux or wrong range compare shows up as wrong data bits. The data tests use distinct per-group patterns, the boundary where the select value equals the count, and a group beyond the implemented records.

// File: rtl/errgrp_pkg.sv
package errgrp_pkg;

    typedef enum logic [3:0] {
        OUT_NONE  = 4'b0000,
        OUT_READ  = 4'b0001,
        OUT_UNDEF = 4'b0010,
        OUT_TRAP2 = 4'b0100,
        OUT_TRAP3 = 4'b1000
    } outcome_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

    localparam logic [5:0] TRAP_EC = 6'h18;

    localparam logic [1:0] ENC_OP0 = 2'b11;
    localparam logic [2:0] ENC_OP1 = 3'b000;
    localparam logic [3:0] ENC_CRN = 4'b0101;
    localparam logic [3:0] ENC_CRM = 4'b0011;
    localparam logic [2:0] ENC_OP2 = 3'b010;

    typedef struct packed {
        logic [1:0]  op0;
        logic [2:0]  op1;
        logic [3:0]  crn;
        logic [3:0]  crm;
        logic [2:0]  op2;
        logic        feat;
        logic [1:0]  el;
        logic [15:0] sel;
        logic [15:0] cnt;
        logic        el3_impl;
        logic        el2_active;
        logic        l3_trap;
        logic        l3_uprio;
        logic        l3_dbg_undef;
        logic        l2_trap;
        logic        fgt2_impl;
        logic        l3_fgt2_en;
        logic        l2_rd_en;
    } req_t;

endpackage

// File: rtl/errgrp_check.sv
module errgrp_check
    import errgrp_pkg::*;
(
    input  req_t     rq,
    output outcome_e kind
);
    logic enc_hit;
    logic l3_undef_first;
    logic l3_trap_hit;

    assign enc_hit = (rq.op0 == ENC_OP0) && (rq.op1 == ENC_OP1) &&
                     (rq.crn == ENC_CRN) && (rq.crm == ENC_CRM) &&
                     (rq.op2 == ENC_OP2);
    assign l3_undef_first = rq.el3_impl && rq.l3_uprio && rq.l3_trap;
    assign l3_trap_hit    = rq.el3_impl && rq.l3_trap;

    always_comb begin
        kind = OUT_READ;
        if (!enc_hit || !rq.feat) begin
            kind = OUT_UNDEF;
        end else begin
            unique case (rq.el)
                2'd0: kind = OUT_UNDEF;
                2'd1: begin
                    if (l3_undef_first)
                        kind = OUT_UNDEF;
                    else if (rq.el2_active && rq.l2_trap)
                        kind = OUT_TRAP2;
                    else if (rq.el2_active && rq.fgt2_impl &&
                             ((rq.el3_impl && !rq.l3_fgt2_en) || !rq.l2_rd_en))
                        kind = OUT_TRAP2;
                    else if (l3_trap_hit)
                        kind = rq.l3_dbg_undef ? OUT_UNDEF : OUT_TRAP3;
                    else
                        kind = OUT_READ;
                end
                2'd2: begin
                    if (l3_undef_first)
                        kind = OUT_UNDEF;
                    else if (l3_trap_hit)
                        kind = rq.l3_dbg_undef ? OUT_UNDEF : OUT_TRAP3;
                    else
                        kind = OUT_READ;
                end
                default: kind = OUT_READ;
            endcase
        end
    end
endmodule

// File: rtl/errgrp_gather.sv
module errgrp_gather #(
    parameter int NREC = 256,
    parameter int GW   = 64,
    parameter int SELW = 16
) (
    input  logic [SELW-1:0] sel,
    input  logic [SELW-1:0] cnt,
    input  logic [NREC-1:0] valid,
    input  logic [NREC-1:0] impl,
    output logic [GW-1:0]   word
);
    localparam int GSH  = $clog2(GW);
    localparam int NGRP = (NREC + GW - 1) / GW;
    localparam int PADW = NGRP * GW;
    localparam int GIW  = SELW - GSH;

    logic [PADW-1:0] live;
    logic [GIW-1:0]  grp;
    logic            in_range;
    logic [GW-1:0]   picked;

    assign live     = PADW'(valid & impl);
    assign grp      = sel[SELW-1:GSH];
    assign in_range = (cnt != '0) && (sel < cnt);

    for (genvar q = 0; q < GW; q++) begin : g_bit
        always_comb begin
            picked[q] = 1'b0;
            for (int g = 0; g < NGRP; g++) begin
                if (grp == GIW'(g))
                    picked[q] = live[g*GW + q];
            end
        end
    end

    assign word = in_range ? picked : '0;
endmodule

// File: rtl/errgrp_status_rd.sv
module errgrp_status_rd
    import errgrp_pkg::*;
#(
    parameter int NREC = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic [1:0]      acc_op0_i,
    input  logic [2:0]      acc_op1_i,
    input  logic [3:0]      acc_crn_i,
    input  logic [3:0]      acc_crm_i,
    input  logic [2:0]      acc_op2_i,
    input  logic            feat_en_i,
    input  logic [1:0]      cur_el_i,
    input  logic [15:0]     rec_sel_i,
    input  logic [15:0]     rec_count_i,
    input  logic [NREC-1:0] rec_valid_i,
    input  logic [NREC-1:0] rec_impl_i,
    input  logic            el3_impl_i,
    input  logic            el2_active_i,
    input  logic            l3_err_trap_i,
    input  logic            l3_undef_prio_i,
    input  logic            l3_dbg_undef_i,
    input  logic            l2_err_trap_i,
    input  logic            fgt2_impl_i,
    input  logic            l3_fgt2_en_i,
    input  logic            l2_grp_rd_en_i,
    output logic            resp_valid_o,
    output logic [3:0]      resp_kind_o,
    output logic [63:0]     rdata_o,
    output logic [5:0]      trap_ec_o
);
    localparam int GW = 64;

    state_e   state_q, state_d;
    req_t     rq;
    outcome_e kind;
    logic [GW-1:0] word;

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq <= '0;
        end else if (req_i) begin
            rq <= '{op0: acc_op0_i, op1: acc_op1_i, crn: acc_crn_i,
                    crm: acc_crm_i, op2: acc_op2_i, feat: feat_en_i,
                    el: cur_el_i, sel: rec_sel_i, cnt: rec_count_i,
                    el3_impl: el3_impl_i, el2_active: el2_active_i,
                    l3_trap: l3_err_trap_i, l3_uprio: l3_undef_prio_i,
                    l3_dbg_undef: l3_dbg_undef_i, l2_trap: l2_err_trap_i,
                    fgt2_impl: fgt2_impl_i, l3_fgt2_en: l3_fgt2_en_i,
                    l2_rd_en: l2_grp_rd_en_i};
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_i ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    errgrp_check u_check (
        .rq   (rq),
        .kind (kind)
    );

    errgrp_gather #(.NREC(NREC), .GW(GW), .SELW(16)) u_gather (
        .sel   (rq.sel),
        .cnt   (rq.cnt),
        .valid (rec_valid_i),
        .impl  (rec_impl_i),
        .word  (word)
    );

    // outputs
    always_comb begin
        resp_valid_o = 1'b0;
        resp_kind_o  = OUT_NONE;
        rdata_o      = '0;
        trap_ec_o    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                resp_valid_o = 1'b1;
                resp_kind_o  = kind;
                rdata_o      = (kind == OUT_READ) ? word : '0;
                trap_ec_o    = (kind == OUT_TRAP2 || kind == OUT_TRAP3) ? TRAP_EC : '0;
            end
            default: ;
        endcase
    end

    a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> resp_valid_o);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !resp_valid_o);
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |-> ($countones(resp_kind_o) == 1));
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid_o |-> (resp_kind_o == 4'b0000));
    a_r4_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cur_el_i == 2'd0) |=> (resp_kind_o == 4'b0010));
    a_r7_el3_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cur_el_i == 2'd3 && feat_en_i && acc_op0_i == 2'b11 &&
         acc_op1_i == 3'b000 && acc_crn_i == 4'b0101 &&
         acc_crm_i == 4'b0011 && acc_op2_i == 3'b010) |=> (resp_kind_o == 4'b0001));
    a_r8_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |-> ((trap_ec_o == 6'h18) == (resp_kind_o[2] || resp_kind_o[3])));
    a_r10_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && rec_sel_i >= rec_count_i) |=> (rdata_o == 64'd0));
    a_r11_data_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_kind_o[0] |-> (rdata_o == 64'd0));
endmodule

// File: tb/tb_errgrp_status_rd.sv
module tb_errgrp_status_rd;
    localparam int NREC = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_i = 1'b0;
    logic [1:0]      op0 = 2'b11;
    logic [2:0]      op1 = 3'b000;
    logic [3:0]      crn = 4'b0101;
    logic [3:0]      crm = 4'b0011;
    logic [2:0]      op2 = 3'b010;
    logic            feat = 1'b1;
    logic [1:0]      el = 2'd3;
    logic [15:0]     sel = '0;
    logic [15:0]     cnt = 16'd256;
    logic [NREC-1:0] rvalid;
    logic [NREC-1:0] rimpl;
    logic el3p = 0, e2 = 0, t3 = 0, uprio = 0, sdd = 0, t2 = 0, fgt = 0, fen = 1, rden = 1;
    logic            resp_valid;
    logic [3:0]      resp_kind;
    logic [63:0]     rdata;
    logic [5:0]      ec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    errgrp_status_rd #(.NREC(NREC)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .acc_op0_i(op0), .acc_op1_i(op1), .acc_crn_i(crn), .acc_crm_i(crm), .acc_op2_i(op2),
        .feat_en_i(feat), .cur_el_i(el), .rec_sel_i(sel), .rec_count_i(cnt),
        .rec_valid_i(rvalid), .rec_impl_i(rimpl),
        .el3_impl_i(el3p), .el2_active_i(e2), .l3_err_trap_i(t3), .l3_undef_prio_i(uprio),
        .l3_dbg_undef_i(sdd), .l2_err_trap_i(t2), .fgt2_impl_i(fgt), .l3_fgt2_en_i(fen),
        .l2_grp_rd_en_i(rden),
        .resp_valid_o(resp_valid), .resp_kind_o(resp_kind), .rdata_o(rdata), .trap_ec_o(ec)
    );

    localparam logic [63:0] G0 = 64'h8000_0000_0000_0001;
    localparam logic [63:0] G1 = 64'h0000_4567_89AB_0000;
    localparam logic [63:0] G2 = 64'hAAAA_AAAA_AAAA_AAAA;
    localparam logic [63:0] G3 = 64'hFFFF_0000_FFFF_0000;

    typedef struct packed {
        logic [1:0]  el;
        logic [15:0] sel;
        logic [15:0] num;
        logic [3:0]  kind;
        logic [63:0] data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{2'd3, 16'd0,   16'd256, 4'b0001, G0},     // R9 group 0
        '{2'd3, 16'd69,  16'd256, 4'b0001, G1},     // R9 group 1, masked by implemented flags
        '{2'd3, 16'd130, 16'd256, 4'b0001, G2},     // R9 group 2
        '{2'd3, 16'd255, 16'd256, 4'b0001, G3},     // R9 last record
        '{2'd3, 16'd200, 16'd200, 4'b0001, 64'd0},  // R10 select equals count
        '{2'd3, 16'd199, 16'd200, 4'b0001, G3},     // R10 just below count
        '{2'd3, 16'd0,   16'd0,   4'b0001, 64'd0},  // R10 count zero
        '{2'd3, 16'd300, 16'd400, 4'b0001, 64'd0},  // R9 group beyond NREC
        '{2'd1, 16'd63,  16'd64,  4'b0001, G0},     // R9 level 1 read
        '{2'd0, 16'd0,   16'd256, 4'b0010, 64'd0}   // R4 level 0
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one request; samples at the negedge after the capturing edge
    task automatic do_req();
        @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    function automatic logic [3:0] ref_kind(input logic [1:0] l, input logic p3, input logic a2,
        input logic tr3, input logic up, input logic dbg, input logic tr2, input logic fg,
        input logic fe, input logic rd);
        if (l == 2'd0) return 4'b0010;                       // R4
        if (l == 2'd3) return 4'b0001;                       // R7
        if (p3 && up && tr3) return 4'b0010;                 // R5 / R6 first check
        if (l == 2'd1) begin                                 // R5 level-2 checks
            if (a2 && tr2) return 4'b0100;
            if (a2 && fg && ((p3 && !fe) || !rd)) return 4'b0100;
        end
        if (p3 && tr3) return dbg ? 4'b0010 : 4'b1000;
        return 4'b0001;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rvalid = {64'hFFFF_0000_FFFF_0000, G2, 64'h0123_4567_89AB_CDEF, G0};
        rimpl  = {{128{1'b1}}, 64'h0000_FFFF_FFFF_0000, {64{1'b1}}};

        // R12 reset state
        repeat (2) @(negedge clk);
        check("R12 valid in reset", 64'(resp_valid), 64'd0);
        check("R12 kind in reset", 64'(resp_kind), 64'd0);
        check("R12 data in reset", rdata, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 valid after reset", 64'(resp_valid), 64'd0);
        check("R12 ec after reset", 64'(ec), 64'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            el = TBL[i].el; sel = TBL[i].sel; cnt = TBL[i].num;
            do_req();
            check("R1 table valid", 64'(resp_valid), 64'd1);
            check("R9/R10 table kind", 64'(resp_kind), 64'(TBL[i].kind));
            check("R9/R10 table data", rdata, TBL[i].data);
        end
        @(negedge clk);
        check("R1 response lasts one cycle", 64'(resp_valid), 64'd0);
        check("R2 kind zero when idle", 64'(resp_kind), 64'd0);

        // exhaustive control sweep, R5 R6 R7 R8 R11
        sel = 16'd0; cnt = 16'd256;
        for (int l = 0; l < 4; l++) begin
            for (int c = 0; c < 512; c++) begin
                logic [3:0] ek;
                el = 2'(l);
                {el3p, e2, t3, uprio, sdd, t2, fgt, fen, rden} = 9'(c);
                ek = ref_kind(el, el3p, e2, t3, uprio, sdd, t2, fgt, fen, rden);
                do_req();
                check("R5/R6/R7 outcome", 64'(resp_kind), 64'(ek));
                check("R8 trap class", 64'(ec), (ek[2] || ek[3]) ? 64'h18 : 64'd0);
                check("R11 data gated", rdata, (ek == 4'b0001) ? G0 : 64'd0);
            end
        end
        {el3p, e2, t3, uprio, sdd, t2, fgt, fen, rden} = 9'b0_0000_0011;

        // R3 encoding and feature
        el = 2'd3;
        op2 = 3'b011; do_req(); check("R3 op2 mismatch", 64'(resp_kind), 64'b0010); op2 = 3'b010;
        crm = 4'b0100; do_req(); check("R3 CRm mismatch", 64'(resp_kind), 64'b0010); crm = 4'b0011;
        crn = 4'b0100; do_req(); check("R3 CRn mismatch", 64'(resp_kind), 64'b0010); crn = 4'b0101;
        op1 = 3'b001; do_req(); check("R3 op1 mismatch", 64'(resp_kind), 64'b0010); op1 = 3'b000;
        op0 = 2'b10; do_req(); check("R3 op0 mismatch", 64'(resp_kind), 64'b0010);
        check("R11 undef data", rdata, 64'd0); op0 = 2'b11;
        feat = 1'b0; do_req(); check("R3 feature absent", 64'(resp_kind), 64'b0010); feat = 1'b1;

        // R1 back to back requests with changing select
        @(negedge clk);
        req_i = 1'b1; sel = 16'd64;
        @(negedge clk);
        check("R1 b2b first", rdata, G1);
        sel = 16'd128;
        @(negedge clk);
        check("R1 b2b second valid", 64'(resp_valid), 64'd1);
        check("R1 b2b second", rdata, G2);
        req_i = 1'b0;
        @(negedge clk);
        check("R1 b2b ends", 64'(resp_valid), 64'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule